// File: doc/BRIEF.md
# Guarded Byte-Wide Static RAM

This block stands in for a byte-wide static RAM whose pins follow the usual active-low convention. There is a chip select, an output gate and a write strobe, plus an active-high write-protect line that shuts the device down. The pins are not sampled on their own edges. A fast system clock samples them, so they may come straight from another clock domain or from a pin-level sequencer. The bidirectional data bus is split into a data input, a data output and an output-drive flag, and the flag stands in for the tristate enable. The pins form a plain SRAM-style strobe interface, so no valid/ready handshake is involved and no back-pressure exists: every sampled cycle is acted on.

The block decodes three modes from the strobes: idle, read and write. A write lasts exactly as long as chip select and write strobe are both low. The byte is committed when the first of the two returns high, using the address and data seen in the last sampled cycle before that rise. Raising the protect line forces the outputs off and makes every strobe meaningless. A write that is still open when protect rises is dropped.

The address width is a parameter. The full 8K x 8 configuration uses ADDR_W = 13. The default is a smaller 1K array so that the whole array can be swept.

Top module: `bwram_guarded`

## Requirements
- R1: The array holds 2^ADDR_W bytes. A byte written to an address is returned by every later read of that address until it is rewritten, and writes never disturb other addresses.
- R2: While chip select (ce_n) is high, dq_oe is low and the write strobe, output gate, address and data are ignored: no byte is written.
- R3: With ce_n low, we_n high, oe_n low and wp low, dq_oe is high and dq_out carries the byte stored at addr.
- R4: With ce_n low and we_n high but oe_n high, dq_oe stays low.
- R5: A write window is open while ce_n and we_n are both low. It closes on whichever strobe rises first, and the closing strobe may be either one. The stored byte and its address are the din and addr of the last sampled cycle before the close, and earlier din values in the window are discarded.
- R6: If the outputs are driving and we_n falls, dq_oe goes low and stays low for as long as we_n is low.
- R7: If ce_n and we_n fall in the same sampled cycle, dq_oe never goes high during that access.
- R8: While wp is high, dq_oe is low and no byte is written, whatever the strobes do.
- R9: If wp rises while a write window is open, that write is dropped and the addressed byte keeps its old value. After wp falls, no new window opens until ce_n or we_n has been seen high.
- R10: Every pin passes through a two-stage synchronizer, and an output register follows the synchronizer. dq_oe and dq_out therefore reflect the pin values from exactly three clock edges earlier. dq_out is zero whenever dq_oe is low.
- R11: Reset is asynchronous and active low. During and right after reset, dq_oe is low and dq_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| wp | input | 1 | Write-protect / forced deselect, active high |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data (bus inbound half) |
| dq_out | output | DATA_W | Read data (bus outbound half), zero when not driving |
| dq_oe | output | 1 | High when the data bus would be driven |

## Verification
The checker's properties rest on one assumption: the pins are level signals that hold their value long enough to be sampled, and the output flag is judged against the pins as sampled three edges earlier. The bench drives every pin on the falling clock edge and holds each level for at least one full cycle. It keeps addr steady for a whole write window and changes din only inside the window, which matches the hold rules a real part would demand. Expected bytes come from an arithmetic pattern over the address, held in a shadow array in the bench. Read checks are sampled three rising edges after the stimulus.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } mode_t;

  function automatic mode_t decode_mode(input logic ce_n, input logic we_n);
    if (ce_n)      return MODE_OFF;
    else if (we_n) return MODE_READ;
    else           return MODE_WRITE;
  endfunction

endpackage

// File: rtl/bwr_sync.sv
module bwr_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/bwr_window.sv
module bwr_window #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              prot_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              armed_q;
  logic              open_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              open_now;
  logic              any_high;

  assign any_high = ce_s | we_s;
  assign open_now = armed_q & ~ce_s & ~we_s & ~prot_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      open_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (prot_s)        armed_q <= 1'b0;
      else if (any_high) armed_q <= 1'b1;
      open_q <= open_now;
      if (open_now) begin
        addr_q <= addr_s;
        data_q <= din_s;
      end
    end
  end

  assign wr_en   = open_q & ~open_now & ~prot_s & any_high;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

endmodule

// File: rtl/bwr_array.sv
module bwr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/bwram_guarded.sv
module bwram_guarded #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wp,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  import bwr_pkg::*;

  localparam int CTL_W = 4;
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [CTL_W-1:0]  ctl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              ce_s, oe_s, we_s, prot_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  mode_t             mode;
  logic              drive;
  logic              oe_q;
  logic [DATA_W-1:0] out_q;

  bwr_sync #(.W(CTL_W), .RST_VAL(4'b1111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({wp, ce_n, oe_n, we_n}), .q(ctl_s)
  );

  bwr_sync #(.W(BUS_W), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s)
  );

  assign {prot_s, ce_s, oe_s, we_s} = ctl_s;
  assign {addr_s, din_s}            = bus_s;

  bwr_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_window (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .we_s(we_s), .prot_s(prot_s),
    .addr_s(addr_s), .din_s(din_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  bwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr_s), .rd_data(rd_data)
  );

  assign mode  = decode_mode(ce_s, we_s);
  assign drive = ~prot_s & ~oe_s & (mode == MODE_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      out_q <= '0;
    end else begin
      oe_q  <= drive;
      out_q <= drive ? rd_data : '0;
    end
  end

  assign dq_oe  = oe_q;
  assign dq_out = out_q;

endmodule

// File: rtl/bwr_guard_chk.sv
module bwr_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              wp,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);

  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assign warm = (age_q == 2'd3);

  p_deselect_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(ce_n, 3)) |-> !dq_oe);

  p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(ce_n, 3) && $past(we_n, 3) && !$past(oe_n, 3) && !$past(wp, 3))
      |-> dq_oe);

  p_gate_off_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(oe_n, 3)) |-> !dq_oe);

  p_write_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(we_n, 3)) |-> !dq_oe);

  p_protect_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(wp, 3)) |-> !dq_oe);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

endmodule

bind bwram_guarded bwr_guard_chk #(.DATA_W(DATA_W)) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .wp(wp), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/bwram_guarded_tb_top.sv
`timescale 1ns/1ps
module bwram_guarded_tb_top;

  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] shadow [DEPTH];

  always #10 clk = ~clk;

  bwram_guarded #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wp(wp), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] pattern(input int a);
    int v;
    v = (a * 37 + 5) ^ (a >> 3);
    return v[DW-1:0];
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // write closed by the write strobe rising (R5)
  task automatic write_by_we(input int a, input logic [DW-1:0] d);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = a[AW-1:0]; din = ~d;
    step(1);
    we_n = 1'b0; step(2);
    din = d; step(2);
    we_n = 1'b1; step(1);
    ce_n = 1'b1; din = 8'h00; step(1);
  endtask

  // write closed by chip select rising (R5)
  task automatic write_by_ce(input int a, input logic [DW-1:0] d);
    ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = a[AW-1:0]; din = ~d;
    step(1);
    ce_n = 1'b0; step(2);
    din = d; step(2);
    ce_n = 1'b1; step(1);
    we_n = 1'b1; din = 8'h00; step(1);
  endtask

  task automatic read_chk(input string req, input int a);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a[AW-1:0];
    step(3);
    check(req, int'(dq_oe), 1);
    check(req, int'(dq_out), int'(shadow[a]));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int hi_seen;
    // R11 reset state
    step(3);
    check("R11 oe", int'(dq_oe), 0);
    check("R11 data", int'(dq_out), 0);
    rst_n = 1'b1;
    step(2);
    check("R11 after release", int'(dq_oe), 0);

    // R1 and R5 sweep: every address, alternating the closing strobe
    for (int a = 0; a < DEPTH; a++) begin
      shadow[a] = pattern(a);
      if (a % 2 == 0) write_by_we(a, shadow[a]);
      else            write_by_ce(a, shadow[a]);
    end
    for (int a = 0; a < DEPTH; a++) read_chk("R1/R3/R5 sweep", a);

    // R10 latency: output changes on the third rising edge
    ce_n = 1'b1; step(4);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 10'd40;
    step(2);
    check("R10 two edges", int'(dq_oe), 0);
    step(1);
    check("R10 three edges", int'(dq_oe), 1);
    check("R10 data", int'(dq_out), int'(shadow[40]));

    // R4 output gate high
    oe_n = 1'b1; step(4);
    check("R4 oe", int'(dq_oe), 0);
    check("R4 zero data", int'(dq_out), 0);

    // R2 deselected: strobes ignored
    ce_n = 1'b1; oe_n = 1'b0; addr = 10'd11; din = 8'hA5;
    for (int k = 0; k < 4; k++) begin
      we_n = 1'b0; step(2);
      check("R2 deselect oe", int'(dq_oe), 0);
      we_n = 1'b1; step(2);
    end
    read_chk("R2 no write", 11);

    // R6 write strobe falling while driving
    read_chk("R6 setup", 9);
    we_n = 1'b0; din = 8'h5A; step(3);
    check("R6 oe off", int'(dq_oe), 0);
    step(3);
    check("R6 stays off", int'(dq_oe), 0);
    we_n = 1'b1; shadow[9] = 8'h5A; step(1);
    ce_n = 1'b1; step(2);
    read_chk("R6 committed", 9);

    // R7 simultaneous fall never drives
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = 10'd10; step(4);
    ce_n = 1'b0; we_n = 1'b0; din = 8'h3C;
    hi_seen = 0;
    for (int k = 0; k < 6; k++) begin
      step(1);
      if (dq_oe) hi_seen = 1;
    end
    ce_n = 1'b1; we_n = 1'b1; shadow[10] = 8'h3C;
    for (int k = 0; k < 4; k++) begin
      step(1);
      if (dq_oe) hi_seen = 1;
    end
    check("R7 never driven", hi_seen, 0);
    read_chk("R7 write landed", 10);

    // R8 protect: no drive, no write
    wp = 1'b1; step(3);
    write_by_we(5, 8'hEE);
    write_by_ce(5, 8'hEF);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 10'd5; step(3);
    check("R8 protect oe", int'(dq_oe), 0);
    check("R8 protect data", int'(dq_out), 0);
    wp = 1'b0; step(1);
    read_chk("R8 byte kept", 5);

    // R9 protect during an open window aborts; no re-arm while both low
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step(2);
    ce_n = 1'b0; we_n = 1'b0; addr = 10'd6; din = 8'h77; step(3);
    wp = 1'b1; step(3);
    wp = 1'b0; step(4);
    we_n = 1'b1; step(1);
    ce_n = 1'b1; step(2);
    read_chk("R9 aborted write", 6);

    // R9 a fresh window after protect works again
    write_by_we(6, 8'h99);
    shadow[6] = 8'h99;
    read_chk("R9 next write", 6);
    read_chk("R1 neighbour", 7);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule